// File: doc/BRIEF.md
# Configurable Event Action Engine

The engine sits behind an event matcher. It takes match packets one at a time. Each packet carries a unit number, an address and a data word. The unit number picks a start pointer and an entry count from a per-unit sequence register. Those two values mark a run of entries in a shared action table. The entries run strictly in order, one per cycle.

Each entry is one of four kinds:
- an ALU micro-operation over two selected operands;
- a memory load;
- a memory store;
- a skip.

Operands can be the packet's address or data, the entry's immediate, the last memory response, or one of the local registers. A result can go to a local register, be discarded, or go to a sticky interrupt register that signals the host.

A load stalls the sequence until its response returns. A typical program is a shadow stack built from two units. The call unit stores the return address and bumps a stack pointer held in a local register. The return unit pops the pointer, loads the saved value, and compares it with the packet data using set-not-equal, with the interrupt register as the destination.

Software fills the table and the sequence registers through plain write strobes. A new packet is accepted only once the current sequence is finished.

Top module: `evt_action_engine`

## Requirements
- R1: After reset, irq is low, mem_req_valid is low, pkt_ready is high, and all local registers and the response register read as zero.
- R2: pkt_ready is high exactly while the engine is idle. An accepted packet for unit u runs seq_cnt[u] entries, starting at seq_ptr[u]; the index wraps modulo the table depth. A count of zero consumes the packet and runs nothing.
- R3: Operand select codes are: 0 packet address, 1 packet data, 2 entry immediate, 3 last memory response, 4+i local register i (i = 0..3).
- R4: ALU function codes are: 0 add, 1 subtract (first minus second), 2 and, 3 or, 4 xor, 5 set-equal (1 or 0), 6 set-not-equal (1 or 0), 7 pass first operand. Codes 8 to 15 produce zero.
- R5: Destination codes are: 0 discard, 1 interrupt register, 2+i local register i. Codes 6 and 7 are discarded and change no state.
- R6: Kind 2 (store) drives mem_req_valid with mem_req_write=1 for one cycle. The address is the first operand and the write data is the second operand. The next entry runs in the following cycle.
- R7: Kind 1 (load) drives one read request, with the address taken from the first operand, then stalls. A mem_resp_valid arriving one or more cycles after the request is latched into the response register and written to the destination. A load costs one cycle plus the response latency.
- R8: Writing a nonzero value to the interrupt register sets irq. Writing zero leaves irq unchanged. irq stays high until irq_clr is sampled high. A set in the same cycle as irq_clr wins.
- R9: Kind 3 (skip) uses one cycle and has no other effect.
- R10: For a sequence of n entries with no loads, pkt_ready stays low for exactly n cycles after the accepting edge, so no second packet can be popped during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Match packet available |
| pkt_ready | output | 1 | Engine idle; packet is popped when valid and ready |
| pkt_unit | input | 2 | Match unit number of the packet |
| pkt_addr | input | 64 | Packet address field |
| pkt_data | input | 64 | Packet data field |
| ent_we | input | 1 | Table entry write strobe |
| ent_idx | input | 4 | Table entry index |
| ent_kind | input | 2 | Entry kind: 0 ALU, 1 load, 2 store, 3 skip |
| ent_src_a | input | 3 | First operand select |
| ent_src_b | input | 3 | Second operand select |
| ent_fn | input | 4 | ALU function code |
| ent_dst | input | 3 | Destination select |
| ent_imm | input | 64 | Immediate value |
| seq_we | input | 1 | Sequence register write strobe |
| seq_unit | input | 2 | Unit whose sequence register is written |
| seq_ptr | input | 4 | First table entry for the unit |
| seq_cnt | input | 5 | Number of entries for the unit |
| mem_req_valid | output | 1 | Memory request issued this cycle |
| mem_req_write | output | 1 | 1 store, 0 load |
| mem_req_addr | output | 64 | Request address |
| mem_req_wdata | output | 64 | Store data |
| mem_resp_valid | input | 1 | Load response present |
| mem_resp_data | input | 64 | Load response data |
| irq | output | 1 | Sticky interrupt toward the host |
| irq_clr | input | 1 | Interrupt clear command |

## Verification
A corrupted sequence pointer or remaining count shows at once at pkt_ready: the busy window becomes longer or shorter than the programmed count, and it is measured to the cycle. A wrong operand mux or ALU result stays hidden in a local register until a store exposes it. The bench therefore ends each ALU sequence with a store, which puts the value on mem_req_wdata within the same packet. A lost wait state shows up as a stall length that departs from one plus the response latency, or as a wrong loaded value that then surfaces through irq.

// File: rtl/evt_pkg.sv
package evt_pkg;
   localparam int KIND_W = 2;
   localparam int SEL_W  = 3;
   localparam int FN_W   = 4;

   typedef enum logic [KIND_W-1:0] {
      K_ALU   = 2'd0,
      K_LOAD  = 2'd1,
      K_STORE = 2'd2,
      K_SKIP  = 2'd3
   } act_kind_e;

   localparam logic [SEL_W-1:0] SRC_ADDR = 3'd0;
   localparam logic [SEL_W-1:0] SRC_DATA = 3'd1;
   localparam logic [SEL_W-1:0] SRC_IMM  = 3'd2;
   localparam logic [SEL_W-1:0] SRC_RESP = 3'd3;
   localparam logic [SEL_W-1:0] SRC_LOC0 = 3'd4;

   localparam logic [SEL_W-1:0] DST_NONE = 3'd0;
   localparam logic [SEL_W-1:0] DST_IRQ  = 3'd1;
   localparam logic [SEL_W-1:0] DST_LOC0 = 3'd2;

   localparam logic [FN_W-1:0] FN_ADD  = 4'd0;
   localparam logic [FN_W-1:0] FN_SUB  = 4'd1;
   localparam logic [FN_W-1:0] FN_AND  = 4'd2;
   localparam logic [FN_W-1:0] FN_OR   = 4'd3;
   localparam logic [FN_W-1:0] FN_XOR  = 4'd4;
   localparam logic [FN_W-1:0] FN_SEQ  = 4'd5;
   localparam logic [FN_W-1:0] FN_SNE  = 4'd6;
   localparam logic [FN_W-1:0] FN_PASS = 4'd7;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_WAIT = 2'd2
   } eng_state_e;
endpackage

// File: rtl/evt_cfg_table.sv
module evt_cfg_table
   import evt_pkg::*;
#(
   parameter int TBL_DEPTH   = 16,
   parameter int N_UNITS     = 4,
   parameter int DATA_W      = 64,
   parameter bit RESET_TABLE = 1'b1,
   parameter int TBL_AW      = $clog2(TBL_DEPTH),
   parameter int UNIT_W      = $clog2(N_UNITS),
   parameter int CNT_W       = $clog2(TBL_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ent_we,
   input  logic [TBL_AW-1:0] ent_idx,
   input  logic [KIND_W-1:0] ent_kind,
   input  logic [SEL_W-1:0]  ent_src_a,
   input  logic [SEL_W-1:0]  ent_src_b,
   input  logic [FN_W-1:0]   ent_fn,
   input  logic [SEL_W-1:0]  ent_dst,
   input  logic [DATA_W-1:0] ent_imm,
   input  logic              seq_we,
   input  logic [UNIT_W-1:0] seq_unit,
   input  logic [TBL_AW-1:0] seq_ptr,
   input  logic [CNT_W-1:0]  seq_cnt,
   input  logic [TBL_AW-1:0] rd_idx,
   output logic [KIND_W-1:0] rd_kind,
   output logic [SEL_W-1:0]  rd_src_a,
   output logic [SEL_W-1:0]  rd_src_b,
   output logic [FN_W-1:0]   rd_fn,
   output logic [SEL_W-1:0]  rd_dst,
   output logic [DATA_W-1:0] rd_imm,
   input  logic [UNIT_W-1:0] unit_sel,
   output logic [TBL_AW-1:0] start_ptr,
   output logic [CNT_W-1:0]  start_cnt
);
   localparam int ENT_W = KIND_W + 3 * SEL_W + FN_W + DATA_W;

   logic [ENT_W-1:0]  ent_m [TBL_DEPTH];
   logic [TBL_AW-1:0] ptr_m [N_UNITS];
   logic [CNT_W-1:0]  cnt_m [N_UNITS];
   logic [ENT_W-1:0]  wr_word;

   assign wr_word = {ent_kind, ent_src_a, ent_src_b, ent_fn, ent_dst, ent_imm};

   generate
      if (RESET_TABLE) begin : g_rst_tbl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < TBL_DEPTH; i++) ent_m[i] <= '0;
            end else if (ent_we) begin
               ent_m[ent_idx] <= wr_word;
            end
         end
      end else begin : g_plain_tbl
         always_ff @(posedge clk) begin
            if (ent_we) ent_m[ent_idx] <= wr_word;
         end
      end
   endgenerate

   assign {rd_kind, rd_src_a, rd_src_b, rd_fn, rd_dst, rd_imm} = ent_m[rd_idx];

   for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ptr_m[u] <= '0;
            cnt_m[u] <= '0;
         end else if (seq_we && seq_unit == UNIT_W'(u)) begin
            ptr_m[u] <= seq_ptr;
            cnt_m[u] <= seq_cnt;
         end
      end
   end

   always_comb begin
      start_ptr = '0;
      start_cnt = '0;
      for (int u = 0; u < N_UNITS; u++) begin
         if (unit_sel == UNIT_W'(u)) begin
            start_ptr = ptr_m[u];
            start_cnt = cnt_m[u];
         end
      end
   end
endmodule

// File: rtl/evt_alu.sv
module evt_alu
   import evt_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [FN_W-1:0]   fn,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   always_comb begin
      case (fn)
         FN_ADD:  y = a + b;
         FN_SUB:  y = a - b;
         FN_AND:  y = a & b;
         FN_OR:   y = a | b;
         FN_XOR:  y = a ^ b;
         FN_SEQ:  y = DATA_W'(a == b);
         FN_SNE:  y = DATA_W'(a != b);
         FN_PASS: y = a;
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/evt_local_regs.sv
module evt_local_regs
   import evt_pkg::*;
#(
   parameter int N_LOC  = 4,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] q [N_LOC]
);
   for (genvar i = 0; i < N_LOC; i++) begin : g_loc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[i] <= '0;
         else if (wr_en && wr_idx == SEL_W'(i)) q[i] <= wr_data;
      end
   end
endmodule

// File: rtl/evt_action_engine.sv
module evt_action_engine
   import evt_pkg::*;
#(
   parameter int TBL_DEPTH   = 16,
   parameter int N_UNITS     = 4,
   parameter int N_LOC       = 4,
   parameter int DATA_W      = 64,
   parameter bit RESET_TABLE = 1'b1,
   parameter int TBL_AW      = $clog2(TBL_DEPTH),
   parameter int UNIT_W      = $clog2(N_UNITS),
   parameter int CNT_W       = $clog2(TBL_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_valid,
   output logic              pkt_ready,
   input  logic [UNIT_W-1:0] pkt_unit,
   input  logic [DATA_W-1:0] pkt_addr,
   input  logic [DATA_W-1:0] pkt_data,
   input  logic              ent_we,
   input  logic [TBL_AW-1:0] ent_idx,
   input  logic [KIND_W-1:0] ent_kind,
   input  logic [SEL_W-1:0]  ent_src_a,
   input  logic [SEL_W-1:0]  ent_src_b,
   input  logic [FN_W-1:0]   ent_fn,
   input  logic [SEL_W-1:0]  ent_dst,
   input  logic [DATA_W-1:0] ent_imm,
   input  logic              seq_we,
   input  logic [UNIT_W-1:0] seq_unit,
   input  logic [TBL_AW-1:0] seq_ptr,
   input  logic [CNT_W-1:0]  seq_cnt,
   output logic              mem_req_valid,
   output logic              mem_req_write,
   output logic [DATA_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_resp_valid,
   input  logic [DATA_W-1:0] mem_resp_data,
   output logic              irq,
   input  logic              irq_clr
);
   if (N_LOC < 2 || N_LOC > 4) begin : g_bad_loc
      $error("N_LOC must be 2..4 to fit the select encodings");
   end
   if (TBL_DEPTH < 2 || TBL_DEPTH != (1 << TBL_AW)) begin : g_bad_depth
      $error("TBL_DEPTH must be a power of two, at least 2");
   end
   if (N_UNITS < 2 || N_UNITS != (1 << UNIT_W)) begin : g_bad_units
      $error("N_UNITS must be a power of two, at least 2");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be at least 8");
   end

   eng_state_e        state_q;
   logic [TBL_AW-1:0] cur_q;
   logic [CNT_W-1:0]  rem_q;
   logic [DATA_W-1:0] pkt_addr_q, pkt_data_q, resp_q;
   logic              irq_q;

   logic [KIND_W-1:0] rd_kind;
   logic [SEL_W-1:0]  rd_src_a, rd_src_b, rd_dst;
   logic [FN_W-1:0]   rd_fn;
   logic [DATA_W-1:0] rd_imm;
   logic [TBL_AW-1:0] start_ptr;
   logic [CNT_W-1:0]  start_cnt;

   logic [DATA_W-1:0] loc_q [N_LOC];
   logic [DATA_W-1:0] op_a, op_b, alu_y, wr_val;
   logic              wr_fire, step_done, loc_we, irq_set, wait_q;
   logic [SEL_W-1:0]  loc_idx;
   act_kind_e         kind;

   evt_cfg_table #(
      .TBL_DEPTH(TBL_DEPTH), .N_UNITS(N_UNITS), .DATA_W(DATA_W),
      .RESET_TABLE(RESET_TABLE), .TBL_AW(TBL_AW), .UNIT_W(UNIT_W), .CNT_W(CNT_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .ent_we(ent_we), .ent_idx(ent_idx), .ent_kind(ent_kind),
      .ent_src_a(ent_src_a), .ent_src_b(ent_src_b), .ent_fn(ent_fn),
      .ent_dst(ent_dst), .ent_imm(ent_imm),
      .seq_we(seq_we), .seq_unit(seq_unit), .seq_ptr(seq_ptr), .seq_cnt(seq_cnt),
      .rd_idx(cur_q), .rd_kind(rd_kind), .rd_src_a(rd_src_a), .rd_src_b(rd_src_b),
      .rd_fn(rd_fn), .rd_dst(rd_dst), .rd_imm(rd_imm),
      .unit_sel(pkt_unit), .start_ptr(start_ptr), .start_cnt(start_cnt)
   );

   assign kind = act_kind_e'(rd_kind);

   function automatic logic [DATA_W-1:0] pick(input logic [SEL_W-1:0] s);
      logic [DATA_W-1:0] v;
      v = '0;
      case (s)
         SRC_ADDR: v = pkt_addr_q;
         SRC_DATA: v = pkt_data_q;
         SRC_IMM:  v = rd_imm;
         SRC_RESP: v = resp_q;
         default: begin
            for (int i = 0; i < N_LOC; i++)
               if (s == SRC_LOC0 + SEL_W'(i)) v = loc_q[i];
         end
      endcase
      return v;
   endfunction

   assign op_a = pick(rd_src_a);
   assign op_b = pick(rd_src_b);

   evt_alu #(.DATA_W(DATA_W)) u_alu (.fn(rd_fn), .a(op_a), .b(op_b), .y(alu_y));

   assign wait_q    = (state_q == ST_WAIT);
   assign wr_fire   = (state_q == ST_RUN && kind == K_ALU) || (wait_q && mem_resp_valid);
   assign wr_val    = wait_q ? mem_resp_data : alu_y;
   assign step_done = (state_q == ST_RUN && kind != K_LOAD) || (wait_q && mem_resp_valid);

   assign loc_idx = rd_dst - DST_LOC0;
   assign loc_we  = wr_fire && (rd_dst >= DST_LOC0) && (int'(loc_idx) < N_LOC);
   assign irq_set = wr_fire && (rd_dst == DST_IRQ) && (wr_val != '0);

   evt_local_regs #(.N_LOC(N_LOC), .DATA_W(DATA_W)) u_loc (
      .clk(clk), .rst_n(rst_n), .wr_en(loc_we), .wr_idx(loc_idx),
      .wr_data(wr_val), .q(loc_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cur_q      <= '0;
         rem_q      <= '0;
         pkt_addr_q <= '0;
         pkt_data_q <= '0;
         resp_q     <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (pkt_valid) begin
                  pkt_addr_q <= pkt_addr;
                  pkt_data_q <= pkt_data;
                  if (start_cnt != '0) begin
                     state_q <= ST_RUN;
                     cur_q   <= start_ptr;
                     rem_q   <= start_cnt;
                  end
               end
            end
            ST_RUN: begin
               if (kind == K_LOAD) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_resp_valid) begin
                  resp_q  <= mem_resp_data;
                  state_q <= ST_RUN;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
         if (step_done) begin
            if (rem_q == CNT_W'(1)) begin
               state_q <= ST_IDLE;
            end else begin
               cur_q <= cur_q + 1'b1;
               rem_q <= rem_q - 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq_q <= 1'b0;
      else if (irq_set) irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
   end

   assign irq           = irq_q;
   assign pkt_ready     = (state_q == ST_IDLE);
   assign mem_req_valid = (state_q == ST_RUN) && (kind == K_LOAD || kind == K_STORE);
   assign mem_req_write = (kind == K_STORE);
   assign mem_req_addr  = op_a;
   assign mem_req_wdata = op_b;
endmodule

// File: rtl/evt_action_engine_chk.sv
module evt_action_engine_chk #(
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pkt_valid,
   input logic             pkt_ready,
   input logic             irq,
   input logic             irq_clr,
   input logic             mem_req_valid,
   input logic             mem_req_write,
   input logic             mem_resp_valid,
   input logic             wait_q,
   input logic [CNT_W-1:0] start_cnt
);
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_ready |-> !mem_req_valid)
      else $error("request issued while idle");

   p_pop_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && pkt_ready && start_cnt != '0) |=> !pkt_ready)
      else $error("engine still ready after accepting a non-empty sequence");

   p_load_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_write) |=> wait_q)
      else $error("load did not enter the wait state");

   p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_q && !mem_resp_valid) |=> wait_q)
      else $error("wait left without a response");

   p_wait_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q |-> (!mem_req_valid && !pkt_ready))
      else $error("activity during load wait");

   p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq)
      else $error("irq dropped without clear");

   p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(irq_clr))
      else $error("irq fell without a clear command");
endmodule

bind evt_action_engine evt_action_engine_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
   .irq(irq), .irq_clr(irq_clr), .mem_req_valid(mem_req_valid),
   .mem_req_write(mem_req_write), .mem_resp_valid(mem_resp_valid),
   .wait_q(wait_q), .start_cnt(start_cnt)
);

// File: tb/evt_action_engine_tb.sv
module evt_action_engine_tb;
   import evt_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pkt_valid = 1'b0, pkt_ready;
   logic [1:0]  pkt_unit = '0;
   logic [63:0] pkt_addr = '0, pkt_data = '0;
   logic        ent_we = 1'b0;
   logic [3:0]  ent_idx = '0;
   logic [1:0]  ent_kind = '0;
   logic [2:0]  ent_src_a = '0, ent_src_b = '0, ent_dst = '0;
   logic [3:0]  ent_fn = '0;
   logic [63:0] ent_imm = '0;
   logic        seq_we = 1'b0;
   logic [1:0]  seq_unit = '0;
   logic [3:0]  seq_ptr = '0;
   logic [4:0]  seq_cnt = '0;
   logic        mem_req_valid, mem_req_write;
   logic [63:0] mem_req_addr, mem_req_wdata;
   logic        mem_resp_valid = 1'b0;
   logic [63:0] mem_resp_data = '0;
   logic        irq, irq_clr = 1'b0;

   int n_cmp = 0, n_bad = 0;
   int wr_cnt = 0, rd_cnt = 0, resp_lat = 2, busy = 0, wr_before = 0;
   logic [63:0] last_wr_addr = '1, last_wr_data = '1, last_rd_addr = '1;
   logic [63:0] bmem [16];

   always #2.5 clk = ~clk;

   evt_action_engine u_dut (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
      .pkt_unit(pkt_unit), .pkt_addr(pkt_addr), .pkt_data(pkt_data),
      .ent_we(ent_we), .ent_idx(ent_idx), .ent_kind(ent_kind),
      .ent_src_a(ent_src_a), .ent_src_b(ent_src_b), .ent_fn(ent_fn),
      .ent_dst(ent_dst), .ent_imm(ent_imm),
      .seq_we(seq_we), .seq_unit(seq_unit), .seq_ptr(seq_ptr), .seq_cnt(seq_cnt),
      .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
      .irq(irq), .irq_clr(irq_clr)
   );

   // {fn, a, b, expected}
   localparam logic [195:0] VEC [10] = '{
      {4'd0, 64'h0000_0000_FFFF_FFFF, 64'h1, 64'h0000_0001_0000_0000},
      {4'd1, 64'h5, 64'h7, 64'hFFFF_FFFF_FFFF_FFFE},
      {4'd2, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'hF000_F000_F000_F000},
      {4'd3, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'hFFF0_FFF0_FFF0_FFF0},
      {4'd4, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_0FF0_0FF0},
      {4'd5, 64'h1234, 64'h1234, 64'h1},
      {4'd5, 64'h1234, 64'h1235, 64'h0},
      {4'd6, 64'h1234, 64'h1235, 64'h1},
      {4'd7, 64'hDEAD_BEEF, 64'h1, 64'hDEAD_BEEF},
      {4'd9, 64'h3, 64'h4, 64'h0}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic put_ent(input int idx, input logic [1:0] k, input logic [2:0] a,
                          input logic [2:0] b, input logic [3:0] f,
                          input logic [2:0] d, input logic [63:0] imm);
      @(negedge clk);
      ent_we = 1'b1; ent_idx = 4'(idx); ent_kind = k; ent_src_a = a;
      ent_src_b = b; ent_fn = f; ent_dst = d; ent_imm = imm;
      @(negedge clk);
      ent_we = 1'b0;
   endtask

   task automatic put_seq(input int u, input int ptr, input int cnt);
      @(negedge clk);
      seq_we = 1'b1; seq_unit = 2'(u); seq_ptr = 4'(ptr); seq_cnt = 5'(cnt);
      @(negedge clk);
      seq_we = 1'b0;
   endtask

   task automatic run_pkt(input int u, input logic [63:0] a, input logic [63:0] d);
      @(negedge clk);
      while (!pkt_ready) @(negedge clk);
      pkt_valid = 1'b1; pkt_unit = 2'(u); pkt_addr = a; pkt_data = d;
      @(negedge clk);
      pkt_valid = 1'b0;
      busy = 0;
      while (!pkt_ready) begin
         busy++;
         @(negedge clk);
      end
   endtask

   // memory-side observer
   initial begin
      for (int i = 0; i < 16; i++) bmem[i] = '0;
      forever begin
         @(negedge clk);
         if (mem_req_valid && mem_req_write) begin
            wr_cnt++;
            last_wr_addr = mem_req_addr;
            last_wr_data = mem_req_wdata;
            bmem[mem_req_addr[6:3]] = mem_req_wdata;
         end else if (mem_req_valid) begin
            rd_cnt++;
            last_rd_addr = mem_req_addr;
         end
      end
   end

   // load responder, latency resp_lat cycles (at least 1)
   initial begin
      forever begin
         @(negedge clk);
         mem_resp_valid = 1'b0;
         if (mem_req_valid && !mem_req_write) begin
            logic [3:0] slot;
            slot = mem_req_addr[6:3];
            repeat (resp_lat) @(negedge clk);
            mem_resp_valid = 1'b1;
            mem_resp_data  = bmem[slot];
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq", 64'(irq), 64'h0);
      chk("R1 pkt_ready", 64'(pkt_ready), 64'h1);
      chk("R1 mem_req_valid", 64'(mem_req_valid), 64'h0);

      put_ent(1,  K_STORE, SRC_IMM,  SRC_LOC0,       FN_ADD, DST_NONE, 64'h100);
      put_ent(2,  K_STORE, SRC_IMM,  SRC_LOC0 + 3'd3, FN_ADD, DST_NONE, 64'h108);
      put_ent(3,  K_STORE, SRC_IMM,  SRC_RESP,       FN_ADD, DST_NONE, 64'h108);
      put_ent(4,  K_ALU,   SRC_IMM,  SRC_IMM,        FN_OR,  DST_LOC0 + 3'd1, 64'h40);
      put_ent(5,  K_STORE, SRC_LOC0 + 3'd1, SRC_DATA, FN_ADD, DST_NONE, 64'h0);
      put_ent(6,  K_ALU,   SRC_LOC0 + 3'd1, SRC_IMM, FN_ADD, DST_LOC0 + 3'd1, 64'h8);
      put_ent(7,  K_ALU,   SRC_LOC0 + 3'd1, SRC_IMM, FN_SUB, DST_LOC0 + 3'd1, 64'h8);
      put_ent(8,  K_LOAD,  SRC_LOC0 + 3'd1, SRC_IMM, FN_ADD, DST_LOC0 + 3'd2, 64'h0);
      put_ent(9,  K_ALU,   SRC_LOC0 + 3'd2, SRC_DATA, FN_SNE, DST_IRQ, 64'h0);
      put_ent(10, K_STORE, SRC_IMM,  SRC_RESP,       FN_ADD, DST_NONE, 64'h180);
      put_ent(11, K_SKIP,  SRC_IMM,  SRC_IMM,        FN_OR,  DST_LOC0, 64'hBAD);
      put_ent(12, K_ALU,   SRC_IMM,  SRC_IMM,        FN_SEQ, DST_IRQ, 64'h5);
      put_ent(13, K_ALU,   SRC_IMM,  SRC_IMM,        FN_SNE, DST_IRQ, 64'h5);
      put_ent(14, K_ALU,   SRC_IMM,  SRC_IMM,        FN_OR,  3'd6, 64'h55);
      put_ent(15, K_ALU,   SRC_IMM,  SRC_IMM,        FN_OR,  DST_LOC0 + 3'd2, 64'h77);

      // R1 local register and response register start at zero
      put_seq(0, 2, 1);
      run_pkt(0, 64'h0, 64'h0);
      chk("R1 local reg 3 zero", last_wr_data, 64'h0);
      last_wr_data = '1;
      put_seq(0, 3, 1);
      run_pkt(0, 64'h0, 64'h0);
      chk("R1 response reg zero", last_wr_data, 64'h0);

      // R2 zero count consumes packet
      put_seq(3, 0, 0);
      wr_before = wr_cnt;
      run_pkt(3, 64'h1, 64'h2);
      chk("R2 zero count busy", 64'(busy), 64'h0);
      chk("R2 zero count no request", 64'(wr_cnt - wr_before), 64'h0);

      // R3/R4 ALU vector walk: entry0 ALU(addr,data)->loc0, entry1 store loc0
      put_seq(0, 0, 2);
      for (int i = 0; i < 10; i++) begin
         put_ent(0, K_ALU, SRC_ADDR, SRC_DATA, VEC[i][195:192], DST_LOC0, 64'h0);
         last_wr_data = '1;
         run_pkt(0, VEC[i][191:128], VEC[i][127:64]);
         chk($sformatf("R4 fn %0d vec %0d", VEC[i][195:192], i), last_wr_data, VEC[i][63:0]);
         if (i == 0) begin
            chk("R10 busy for two entries", 64'(busy), 64'h2);
            chk("R6 store address", last_wr_addr, 64'h100);
         end
      end

      // R7 shadow stack: init sp, two calls, two returns
      resp_lat = 3;
      put_seq(0, 4, 1);
      run_pkt(0, 64'h0, 64'h0);
      put_seq(0, 5, 2);
      run_pkt(0, 64'h0, 64'h1111);
      chk("R6 push address", last_wr_addr, 64'h40);
      run_pkt(0, 64'h0, 64'h2222);
      chk("R6 push data", last_wr_data, 64'h2222);
      chk("R3 push address from local reg", last_wr_addr, 64'h48);
      put_seq(1, 7, 3);
      run_pkt(1, 64'h0, 64'h2222);
      chk("R7 load stall length", 64'(busy), 64'h6);
      chk("R7 load address", last_rd_addr, 64'h48);
      chk("R8 matched return no irq", 64'(irq), 64'h0);
      run_pkt(1, 64'h0, 64'h9999);
      chk("R8 mismatched return irq", 64'(irq), 64'h1);
      chk("R7 second load address", last_rd_addr, 64'h40);

      // R9 store response then skip
      put_seq(0, 10, 2);
      wr_before = wr_cnt;
      run_pkt(0, 64'h0, 64'h0);
      chk("R7 response register", last_wr_data, 64'h1111);
      chk("R9 skip busy", 64'(busy), 64'h2);
      chk("R9 skip no request", 64'(wr_cnt - wr_before), 64'h1);

      // R8 clear
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
      chk("R8 clear", 64'(irq), 64'h0);

      // R2 wrap: entries 15 then 0
      put_ent(0, K_STORE, SRC_IMM, SRC_LOC0 + 3'd2, FN_ADD, DST_NONE, 64'h40);
      put_seq(2, 15, 2);
      run_pkt(2, 64'h0, 64'h0);
      chk("R2 wrap data", last_wr_data, 64'h77);
      chk("R2 wrap busy", 64'(busy), 64'h2);

      // R5 destination code 6 discarded
      put_seq(0, 14, 1);
      run_pkt(0, 64'h0, 64'h0);
      chk("R5 discard leaves irq", 64'(irq), 64'h0);
      put_seq(0, 0, 1);
      run_pkt(0, 64'h0, 64'h0);
      chk("R5 discard leaves local 2", last_wr_data, 64'h77);

      // R8 zero write, sticky set, set beats clear
      put_seq(0, 13, 1);
      run_pkt(0, 64'h0, 64'h0);
      chk("R8 zero write no irq", 64'(irq), 64'h0);
      put_seq(0, 12, 1);
      run_pkt(0, 64'h0, 64'h0);
      repeat (3) @(negedge clk);
      chk("R8 irq sticky", 64'(irq), 64'h1);
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk);
      chk("R8 cleared", 64'(irq), 64'h0);
      run_pkt(0, 64'h0, 64'h0);
      irq_clr = 1'b0;
      chk("R8 set wins over clear", 64'(irq), 64'h1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule